// File: doc/BRIEF.md
# Ternary X/Y Match Table

This block is a small ternary match table for packet classification. Each stored rule keeps two bit planes of the full key width, called X and Y, plus a 64-bit action word. Every pair of X and Y bits says how one key bit is judged: don't-care, must be 0, must be 1, or never matches. The table has two independent stages. A lookup presents a 416-bit key and a stage select. All valid rules of that stage are compared in parallel, and the lowest-numbered rule that matches wins.

Rules are loaded through one write port. A plane write (X or Y) is carried in three beats of 64, 192 and 160 bits, lowest-order part first, and lands in the rule on the third beat. An action write is a single beat. A rule becomes live only through an X-plane write that carries the add flag, so the usual order is Y first, then X. One clock after the lookup strobe the block presents a hit flag, the winning index and the action word, and it also splits the action word into its fields.

Top module: `tcam_xy_table`

## Requirements
- R1: Per key bit, the stored (x, y) pair decides the result: 00 matches any key bit, 10 matches only 0, 01 matches only 1, and 11 never matches. A rule hits only if every bit matches.
- R2: wr_plane codes are 0 = Y plane, 1 = X plane, 2 = action word, 3 = no target. A plane write takes three beats with wr_beat = 0, 1, 2, carrying key bits 63:0, 255:64 and 415:256 in the low bits of wr_data. The plane is updated on beat 2.
- R3: A rule's valid flag changes only on an X-plane commit, which sets it to wr_add. A Y-plane write never changes it, and an X commit with wr_add low removes the rule.
- R4: After reset no rule is valid, so every lookup misses, and rs_valid and rs_hit are low.
- R5: When several valid rules of the looked-up stage match, rs_index is the lowest of their indices.
- R6: The results of a lookup appear on the clock edge that samples lk_en. rs_valid is high for exactly that one cycle, and the other result outputs hold until the next lookup.
- R7: On a miss, rs_hit is 0, rs_index is 0 and rs_action is all zeros.
- R8: Rules of one stage never take part in a lookup of the other stage.
- R9: Decoded fields of rs_action: bit 0 drop; bit 1 send to a fixed queue; bits 12:2 queue number; bit 12 count enable; bits 20:13 counter number; bit 20 next-stage enable; bits 26:21 next key select; bit 32 rule-id write-back; bits 45:33 rule id.
- R10: A write that commits in the same cycle as a lookup strobe does not affect that lookup. It is seen from the next lookup onward.
- R11: A write with wr_plane = 3 changes no rule and no valid flag.
- R12: An action write (wr_plane = 2) replaces the rule's action word from wr_data[63:0] in one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write beat present |
| wr_stage | input | 1 | Stage of the rule being written |
| wr_index | input | 3 | Rule index within the stage |
| wr_plane | input | 2 | Write target: 0 Y, 1 X, 2 action, 3 none |
| wr_beat | input | 2 | Beat number of a plane write (0, 1, 2) |
| wr_add | input | 1 | On an X commit: 1 adds the rule, 0 removes it |
| wr_data | input | 192 | Beat data, low-aligned |
| lk_en | input | 1 | Lookup strobe |
| lk_stage | input | 1 | Stage to search |
| lk_key | input | 416 | Lookup key |
| rs_valid | output | 1 | Pulses one cycle after a lookup strobe |
| rs_hit | output | 1 | Last lookup matched a rule |
| rs_index | output | 3 | Winning rule index |
| rs_action | output | 64 | Winning action word |
| rs_drop | output | 1 | Drop request field |
| rs_to_queue | output | 1 | Send to a fixed queue field |
| rs_queue | output | 11 | Queue number field |
| rs_cnt_en | output | 1 | Count enable field |
| rs_cnt_idx | output | 8 | Counter number field |
| rs_next_en | output | 1 | Next-stage enable field |
| rs_next_key | output | 6 | Next key select field |
| rs_rid_wb | output | 1 | Rule-id write-back field |
| rs_rid | output | 13 | Rule id field |

## Verification
The assertions assume that plane writes arrive as complete beat sequences 0, 1, 2 without other write traffic in between, because the staged low chunks are shared by all rules. They also assume stage and index inputs are stable within a sequence. The bench's write tasks always issue whole three-beat sequences to one rule, and they keep lookups apart from the first two beats except in the deliberate same-cycle case. Expected results come from a bench-side model of rules built from the bit-pair coding and the lowest-index priority.

// File: rtl/tcam_xy_pkg.sv
package tcam_xy_pkg;
  typedef enum logic [1:0] {
    PL_Y    = 2'd0,
    PL_X    = 2'd1,
    PL_ACT  = 2'd2,
    PL_NONE = 2'd3
  } plane_e;

  localparam int ACT_W = 64;
endpackage

// File: rtl/tcam_wr_stage.sv
module tcam_wr_stage #(
  parameter int KEY_W  = 416,
  parameter int C0_W   = 64,
  parameter int C1_W   = 192,
  parameter int BEAT_W = 192
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_plane,
  input  logic [1:0]        wr_beat,
  input  logic [BEAT_W-1:0] wr_data,
  output logic              commit_y,
  output logic              commit_x,
  output logic              commit_act,
  output logic [KEY_W-1:0]  line
);
  import tcam_xy_pkg::*;

  localparam int C2_W = KEY_W - C0_W - C1_W;

  logic [C0_W-1:0] lo_q;
  logic [C1_W-1:0] mid_q;
  logic            is_plane;
  logic            lo_en;
  logic            mid_en;

  always_comb begin
    is_plane   = wr_en && ((wr_plane == PL_Y) || (wr_plane == PL_X));
    lo_en      = is_plane && (wr_beat == 2'd0);
    mid_en     = is_plane && (wr_beat == 2'd1);
    commit_y   = wr_en && (wr_plane == PL_Y) && (wr_beat == 2'd2);
    commit_x   = wr_en && (wr_plane == PL_X) && (wr_beat == 2'd2);
    commit_act = wr_en && (wr_plane == PL_ACT);
    line       = {wr_data[C2_W-1:0], mid_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (lo_en)  lo_q  <= wr_data[C0_W-1:0];
    if (mid_en) mid_q <= wr_data[C1_W-1:0];
  end
endmodule

// File: rtl/tcam_entry.sv
module tcam_entry #(
  parameter int KEY_W = 416,
  parameter int ACT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             commit_y,
  input  logic             commit_x,
  input  logic             commit_act,
  input  logic             wr_add,
  input  logic [KEY_W-1:0] line,
  input  logic [ACT_W-1:0] act_in,
  input  logic [KEY_W-1:0] key,
  output logic             valid,
  output logic             match,
  output logic [ACT_W-1:0] act
);
  logic [KEY_W-1:0] x_q;
  logic [KEY_W-1:0] y_q;
  logic [ACT_W-1:0] act_q;
  logic             valid_q;
  logic             valid_d;
  logic             ld_y;
  logic             ld_x;
  logic             ld_act;
  logic [KEY_W-1:0] bad_bits;

  always_comb begin
    ld_y    = sel && commit_y;
    ld_x    = sel && commit_x;
    ld_act  = sel && commit_act;
    valid_d = valid_q;
    if (ld_x) valid_d = wr_add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (ld_y)   y_q   <= line;
    if (ld_x)   x_q   <= line;
    if (ld_act) act_q <= act_in;
  end

  always_comb begin
    bad_bits = (x_q & key) | (y_q & ~key);
    match    = valid_q && (bad_bits == '0);
    valid    = valid_q;
    act      = act_q;
  end

  // R3
  y_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_y && !ld_x) |=> $stable(valid_q));
  // R3
  x_add_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_x && wr_add) |=> valid_q);
  // R3
  x_del_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_x && !wr_add) |=> !valid_q);
  // R3
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_x |=> $stable(valid_q));
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     match,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |match;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tcam_act_decode.sv
module tcam_act_decode (
  input  logic [26:0] lo,
  input  logic [45:32] hi,
  output logic        drop,
  output logic        to_queue,
  output logic [10:0] queue,
  output logic        cnt_en,
  output logic [7:0]  cnt_idx,
  output logic        next_en,
  output logic [5:0]  next_key,
  output logic        rid_wb,
  output logic [12:0] rid
);
  always_comb begin
    drop     = lo[0];
    to_queue = lo[1];
    queue    = lo[12:2];
    cnt_en   = lo[12];
    cnt_idx  = lo[20:13];
    next_en  = lo[20];
    next_key = lo[26:21];
    rid_wb   = hi[32];
    rid      = hi[45:33];
  end
endmodule

// File: rtl/tcam_xy_table.sv
module tcam_xy_table #(
  parameter int KEY_W   = 416,
  parameter int C0_W    = 64,
  parameter int C1_W    = 192,
  parameter int BEAT_W  = 192,
  parameter int ENTRIES = 8,
  parameter int STAGES  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [(STAGES>1?$clog2(STAGES):1)-1:0] wr_stage,
  input  logic [$clog2(ENTRIES)-1:0]             wr_index,
  input  logic [1:0]                             wr_plane,
  input  logic [1:0]                             wr_beat,
  input  logic                                   wr_add,
  input  logic [BEAT_W-1:0]                      wr_data,
  input  logic                                   lk_en,
  input  logic [(STAGES>1?$clog2(STAGES):1)-1:0] lk_stage,
  input  logic [KEY_W-1:0]                       lk_key,
  output logic                                   rs_valid,
  output logic                                   rs_hit,
  output logic [$clog2(ENTRIES)-1:0]             rs_index,
  output logic [63:0]                            rs_action,
  output logic                                   rs_drop,
  output logic                                   rs_to_queue,
  output logic [10:0]                            rs_queue,
  output logic                                   rs_cnt_en,
  output logic [7:0]                             rs_cnt_idx,
  output logic                                   rs_next_en,
  output logic [5:0]                             rs_next_key,
  output logic                                   rs_rid_wb,
  output logic [12:0]                            rs_rid
);
  import tcam_xy_pkg::*;

  localparam int STG_W = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam int IDX_W = $clog2(ENTRIES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // write beat assembly
  logic             commit_y;
  logic             commit_x;
  logic             commit_act;
  logic [KEY_W-1:0] line;

  tcam_wr_stage #(
    .KEY_W (KEY_W),
    .C0_W  (C0_W),
    .C1_W  (C1_W),
    .BEAT_W(BEAT_W)
  ) u_wr (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_plane  (wr_plane),
    .wr_beat   (wr_beat),
    .wr_data   (wr_data),
    .commit_y  (commit_y),
    .commit_x  (commit_x),
    .commit_act(commit_act),
    .line      (line)
  );

  // rule array
  logic [STAGES-1:0][ENTRIES-1:0]            match_all;
  logic [STAGES-1:0][ENTRIES-1:0]            valid_all;
  logic [STAGES-1:0][ENTRIES-1:0][ACT_W-1:0] act_all;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = (wr_stage == STG_W'(s)) && (wr_index == IDX_W'(e));
      tcam_entry #(
        .KEY_W(KEY_W),
        .ACT_W(ACT_W)
      ) u_entry (
        .clk       (clk),
        .rst_n     (rst_n_int),
        .sel       (sel),
        .commit_y  (commit_y),
        .commit_x  (commit_x),
        .commit_act(commit_act),
        .wr_add    (wr_add),
        .line      (line),
        .act_in    (wr_data[ACT_W-1:0]),
        .key       (lk_key),
        .valid     (valid_all[s][e]),
        .match     (match_all[s][e]),
        .act       (act_all[s][e])
      );
    end
  end

  // stage select and priority
  logic [ENTRIES-1:0] match_vec;
  logic               win_hit;
  logic [IDX_W-1:0]   win_idx;
  logic [ACT_W-1:0]   win_act;

  always_comb begin
    match_vec = match_all[lk_stage];
    win_act   = act_all[lk_stage][win_idx];
  end

  tcam_prio #(
    .N    (ENTRIES),
    .IDX_W(IDX_W)
  ) u_prio (
    .match(match_vec),
    .hit  (win_hit),
    .idx  (win_idx)
  );

  // result registers
  logic             rs_valid_q, rs_valid_d;
  logic             rs_hit_q,   rs_hit_d;
  logic [IDX_W-1:0] rs_index_q, rs_index_d;
  logic [ACT_W-1:0] rs_act_q,   rs_act_d;

  always_comb begin
    rs_valid_d = lk_en;
    rs_hit_d   = rs_hit_q;
    rs_index_d = rs_index_q;
    rs_act_d   = rs_act_q;
    if (lk_en) begin
      rs_hit_d   = win_hit;
      rs_index_d = win_hit ? win_idx : '0;
      rs_act_d   = win_hit ? win_act : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rs_valid_q <= 1'b0;
      rs_hit_q   <= 1'b0;
      rs_index_q <= '0;
      rs_act_q   <= '0;
    end else begin
      rs_valid_q <= rs_valid_d;
      rs_hit_q   <= rs_hit_d;
      rs_index_q <= rs_index_d;
      rs_act_q   <= rs_act_d;
    end
  end

  assign rs_valid  = rs_valid_q;
  assign rs_hit    = rs_hit_q;
  assign rs_index  = rs_index_q;
  assign rs_action = rs_act_q;

  tcam_act_decode u_dec (
    .lo      (rs_act_q[26:0]),
    .hi      (rs_act_q[45:32]),
    .drop    (rs_drop),
    .to_queue(rs_to_queue),
    .queue   (rs_queue),
    .cnt_en  (rs_cnt_en),
    .cnt_idx (rs_cnt_idx),
    .next_en (rs_next_en),
    .next_key(rs_next_key),
    .rid_wb  (rs_rid_wb),
    .rid     (rs_rid)
  );

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (lk_en && win_hit) |-> (match_vec[win_idx] &&
      ((match_vec & ((ENTRIES'(1) << win_idx) - ENTRIES'(1))) == '0)));
  // R5
  win_only_if_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (lk_en && win_hit) |-> valid_all[lk_stage][win_idx]);
  // R6
  result_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    lk_en |=> rs_valid);
  // R6
  result_holds_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !lk_en |=> (!rs_valid && $stable(rs_hit) && $stable(rs_index) && $stable(rs_action)));
  // R7
  miss_is_clean_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !rs_hit |-> (rs_action == '0 && rs_index == '0));
  // R2
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $countones({commit_y, commit_x, commit_act}) <= 1);
endmodule

// File: tb/tb_tcam_xy_table.sv
`timescale 1ns/1ps
module tb_tcam_xy_table;
  localparam int KW = 416;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [0:0]   wr_stage;
  logic [2:0]   wr_index;
  logic [1:0]   wr_plane;
  logic [1:0]   wr_beat;
  logic         wr_add;
  logic [191:0] wr_data;
  logic         lk_en;
  logic [0:0]   lk_stage;
  logic [KW-1:0] lk_key;
  logic         rs_valid, rs_hit;
  logic [2:0]   rs_index;
  logic [63:0]  rs_action;
  logic         rs_drop, rs_to_queue, rs_cnt_en, rs_next_en, rs_rid_wb;
  logic [10:0]  rs_queue;
  logic [7:0]   rs_cnt_idx;
  logic [5:0]   rs_next_key;
  logic [12:0]  rs_rid;

  tcam_xy_table dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_stage(wr_stage), .wr_index(wr_index), .wr_plane(wr_plane),
    .wr_beat(wr_beat), .wr_add(wr_add), .wr_data(wr_data),
    .lk_en(lk_en), .lk_stage(lk_stage), .lk_key(lk_key),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_index(rs_index), .rs_action(rs_action),
    .rs_drop(rs_drop), .rs_to_queue(rs_to_queue), .rs_queue(rs_queue),
    .rs_cnt_en(rs_cnt_en), .rs_cnt_idx(rs_cnt_idx), .rs_next_en(rs_next_en),
    .rs_next_key(rs_next_key), .rs_rid_wb(rs_rid_wb), .rs_rid(rs_rid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the rules
  logic [KW-1:0] mx [2][8];
  logic [KW-1:0] my [2][8];
  logic [63:0]   ma [2][8];
  logic          mv [2][8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] actv, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, actv, expv);
    end
  endtask

  function automatic logic [KW-1:0] rkey();
    logic [KW-1:0] k;
    for (int i = 0; i < 13; i++) k[i*32 +: 32] = $urandom;
    return k;
  endfunction

  task automatic expect_lk(input int st, input logic [KW-1:0] k,
                           output bit eh, output int ei, output logic [63:0] ea);
    eh = 0; ei = 0; ea = '0;
    for (int e = 7; e >= 0; e--) begin
      if (mv[st][e] && (((mx[st][e] & k) | (my[st][e] & ~k)) == '0)) begin
        eh = 1; ei = e; ea = ma[st][e];
      end
    end
  endtask

  task automatic compare(input bit eh, input int ei, input logic [63:0] ea, input string req);
    chk(rs_valid == 1'b1, req, "rs_valid", 64'(rs_valid), 64'd1);
    chk(rs_hit == eh, req, "rs_hit", 64'(rs_hit), 64'(eh));
    chk(rs_index == 3'(ei), req, "rs_index", 64'(rs_index), 64'(ei));
    chk(rs_action == ea, req, "rs_action", rs_action, ea);
  endtask

  task automatic look(input int st, input logic [KW-1:0] k, input string req);
    bit eh; int ei; logic [63:0] ea;
    expect_lk(st, k, eh, ei, ea);
    lk_en = 1'b1; lk_stage = 1'(st); lk_key = k;
    @(negedge clk);
    lk_en = 1'b0;
    compare(eh, ei, ea, req);
  endtask

  // three-beat plane write; optional lookup strobe on the commit beat
  task automatic wr_plane3(input int st, input int ix, input logic [1:0] pl, input logic add,
                           input logic [KW-1:0] v, input bit with_lk, input int lst,
                           input logic [KW-1:0] lkk);
    wr_en = 1'b1; wr_stage = 1'(st); wr_index = 3'(ix); wr_plane = pl; wr_add = add;
    wr_beat = 2'd0; wr_data = {128'b0, v[63:0]};
    @(negedge clk);
    wr_beat = 2'd1; wr_data = v[255:64];
    @(negedge clk);
    wr_beat = 2'd2; wr_data = {32'b0, v[415:256]};
    if (with_lk) begin
      lk_en = 1'b1; lk_stage = 1'(lst); lk_key = lkk;
    end
    @(negedge clk);
    wr_en = 1'b0; lk_en = 1'b0;
    if (pl == 2'd0) my[st][ix] = v;
    if (pl == 2'd1) begin mx[st][ix] = v; mv[st][ix] = add; end
  endtask

  task automatic wr_act(input int st, input int ix, input logic [63:0] a);
    wr_en = 1'b1; wr_stage = 1'(st); wr_index = 3'(ix); wr_plane = 2'd2; wr_add = 1'b0;
    wr_beat = 2'd0; wr_data = {128'b0, a};
    @(negedge clk);
    wr_en = 1'b0;
    ma[st][ix] = a;
  endtask

  task automatic add_rule(input int st, input int ix, input logic [KW-1:0] x, input logic [KW-1:0] y);
    wr_plane3(st, ix, 2'd0, 1'b0, y, 0, 0, '0);
    wr_plane3(st, ix, 2'd1, 1'b1, x, 0, 0, '0);
  endtask

  task automatic t_reset();
    chk(rs_valid == 1'b0, "R4", "rs_valid after reset", 64'(rs_valid), 0);
    chk(rs_hit == 1'b0, "R4", "rs_hit after reset", 64'(rs_hit), 0);
    look(0, '0, "R4");
    look(1, rkey(), "R4");
    look(0, rkey(), "R7");
  endtask

  task automatic t_bit_codes();
    logic [KW-1:0] x, y, k;
    x = '0; y = '0;
    x[0] = 1'b1;             // bit0 must be 0
    y[1] = 1'b1;             // bit1 must be 1
    add_rule(0, 5, x, y);
    wr_act(0, 5, 64'h0000_0000_0000_0105);
    x = '0; y = '0; x[7] = 1'b1; y[7] = 1'b1; // never matches
    add_rule(0, 6, x, y);
    k = rkey(); k[0] = 1'b0; k[1] = 1'b1;
    look(0, k, "R1");
    chk(rs_hit && rs_index == 3'd5, "R1", "rule5 hit", 64'(rs_index), 64'd5);
    k[0] = 1'b1; look(0, k, "R1");
    k[0] = 1'b0; k[1] = 1'b0; look(0, k, "R1");
    k = '0; k[1] = 1'b1; k[7] = 1'b1; look(0, k, "R1");
  endtask

  logic [KW-1:0] kref;

  task automatic t_chunks();
    logic [KW-1:0] m, x, y, k;
    int pos [5] = '{63, 64, 255, 256, 415};
    kref = rkey();
    m = '0;
    foreach (pos[i]) m[pos[i]] = 1'b1;
    x = ~kref & m; y = kref & m;
    add_rule(1, 2, x, y);
    look(1, kref, "R2");
    chk(rs_hit && rs_index == 3'd2, "R2", "chunked rule hit", 64'(rs_index), 64'd2);
    foreach (pos[i]) begin
      k = kref; k[pos[i]] = ~k[pos[i]];
      look(1, k, "R2");
    end
    k = kref; k[100] = ~k[100];
    look(1, k, "R2");
  endtask

  task automatic t_valid();
    logic [KW-1:0] k;
    k = kref; k[63] = ~k[63];
    wr_plane3(1, 0, 2'd0, 1'b1, '0, 0, 0, '0);
    look(1, k, "R3");
    chk(rs_hit == 1'b0, "R3", "Y write alone", 64'(rs_hit), 0);
    wr_plane3(1, 0, 2'd1, 1'b0, '0, 0, 0, '0);
    look(1, k, "R3");
    wr_plane3(1, 0, 2'd1, 1'b1, '0, 0, 0, '0);
    look(1, k, "R3");
    chk(rs_hit && rs_index == 3'd0, "R3", "X add live", 64'(rs_index), 0);
    wr_plane3(1, 0, 2'd1, 1'b0, '0, 0, 0, '0);
    look(1, k, "R3");
  endtask

  task automatic t_prio();
    logic [KW-1:0] k;
    add_rule(0, 7, '0, '0);
    add_rule(0, 3, '0, '0);
    add_rule(0, 1, '0, '0);
    wr_act(0, 1, 64'h1);
    k = rkey();
    look(0, k, "R5");
    chk(rs_index == 3'd1, "R5", "lowest of 1,3,7", 64'(rs_index), 1);
    wr_plane3(0, 1, 2'd1, 1'b0, '0, 0, 0, '0);
    k[0] = 1'b1;
    look(0, k, "R5");
    chk(rs_index == 3'd3, "R5", "lowest of 3,7", 64'(rs_index), 3);
    // R6: results hold while idle
    @(negedge clk);
    chk(rs_valid == 1'b0, "R6", "rs_valid pulse", 64'(rs_valid), 0);
    chk(rs_hit && rs_index == 3'd3, "R6", "held index", 64'(rs_index), 3);
  endtask

  task automatic t_stage();
    logic [KW-1:0] k;
    k = kref; k[415] = ~k[415];
    look(1, k, "R8");
    chk(rs_hit == 1'b0, "R8", "stage 1 ignores stage 0", 64'(rs_hit), 0);
    look(0, k, "R8");
  endtask

  task automatic t_action();
    logic [63:0] a;
    a = {18'h0, 13'h1ABC, 1'b1, 5'h0, 6'h2D, 1'b1, 7'h5A, 1'b1, 10'h2F3, 1'b1, 1'b0};
    wr_act(0, 3, a);
    look(0, rkey() | {{KW-1{1'b0}}, 1'b1}, "R12");
    chk(rs_action == a, "R12", "action word", rs_action, a);
    chk(rs_drop == a[0], "R9", "drop", 64'(rs_drop), 64'(a[0]));
    chk(rs_to_queue == a[1], "R9", "to_queue", 64'(rs_to_queue), 64'(a[1]));
    chk(rs_queue == a[12:2], "R9", "queue", 64'(rs_queue), 64'(a[12:2]));
    chk(rs_cnt_en == a[12], "R9", "cnt_en", 64'(rs_cnt_en), 64'(a[12]));
    chk(rs_cnt_idx == a[20:13], "R9", "cnt_idx", 64'(rs_cnt_idx), 64'(a[20:13]));
    chk(rs_next_en == a[20], "R9", "next_en", 64'(rs_next_en), 64'(a[20]));
    chk(rs_next_key == a[26:21], "R9", "next_key", 64'(rs_next_key), 64'(a[26:21]));
    chk(rs_rid_wb == a[32], "R9", "rid_wb", 64'(rs_rid_wb), 64'(a[32]));
    chk(rs_rid == a[45:33], "R9", "rid", 64'(rs_rid), 64'(a[45:33]));
  endtask

  task automatic t_plane3();
    logic [KW-1:0] k;
    k = kref; k[64] = ~k[64];
    wr_plane3(1, 4, 2'd3, 1'b1, '0, 0, 0, '0);
    look(1, k, "R11");
    chk(rs_hit == 1'b0, "R11", "no-target write", 64'(rs_hit), 0);
  endtask

  task automatic t_same_cycle();
    logic [KW-1:0] k;
    bit eh; int ei; logic [63:0] ea;
    k = kref; k[256] = ~k[256];
    wr_act(1, 5, 64'h77);
    wr_plane3(1, 5, 2'd0, 1'b0, '0, 0, 0, '0);
    expect_lk(1, k, eh, ei, ea);
    wr_plane3(1, 5, 2'd1, 1'b1, '0, 1, 1, k);
    compare(eh, ei, ea, "R10");
    chk(rs_hit == 1'b0, "R10", "same-cycle lookup sees old table", 64'(rs_hit), 0);
    look(1, k, "R10");
    chk(rs_hit && rs_index == 3'd5, "R10", "next lookup sees write", 64'(rs_index), 5);
  endtask

  initial begin
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 8; e++) begin
        mx[s][e] = '0; my[s][e] = '0; ma[s][e] = '0; mv[s][e] = 1'b0;
      end
    rst_n = 1'b0; wr_en = 1'b0; wr_stage = '0; wr_index = '0; wr_plane = '0;
    wr_beat = '0; wr_add = 1'b0; wr_data = '0; lk_en = 1'b0; lk_stage = '0; lk_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bit_codes();
    t_chunks();
    t_valid();
    t_prio();
    t_stage();
    t_action();
    t_plane3();
    t_same_cycle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule